// File: doc/BRIEF.md
# Pseudo-Static RAM Device Core

This block models the device side of a byte-wide pseudo-static RAM. All pins are sampled on a system clock. Three active-low control pins choose the cycle type: a chip select, a combined output-enable / refresh-request pin, and a write strobe. While the chip is selected, the shared pin acts as an output enable. While the chip is deselected, it requests refresh. The address is captured when the chip select falls. It is held for the rest of the cycle, whatever the address pins do. Write data is committed when the write strobe returns high.

The block keeps its own 11-bit refresh row counter. Each auto-refresh request steps the counter once. If the request pin is held low past a programmable number of cycles, the block enters self refresh. An internal timer then steps the counter at a fixed interval until the pin is released. A one-cycle pulse marks each wrap of the counter from its top row back to row 0.

The storage is a behavioural array whose depth is a parameter. Address bits above that depth are ignored, so the full-size address port can drive a small simulation array.

Top module: `psram_core`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `dout_en` is 0, `refresh_row` is 0 and `row_wrap` is 0.
- R2: The address is captured at the clock edge where `chip_sel_n` is first seen low. Later changes on `addr` while `chip_sel_n` stays low have no effect on the cycle.
- R3: With `chip_sel_n`=0, `out_en_ref_n`=0 and `write_n`=1, the byte at the captured address appears on `dout` with `dout_en`=1 after the next clock edge.
- R4: A write commits `din` to the captured address at the clock edge where `write_n` is first seen high after being low, with `chip_sel_n` low on both sides of that rise.
- R5: With `chip_sel_n`=0, `out_en_ref_n`=1 and `write_n`=1, `dout_en` is 0 and no cell changes.
- R6: With `chip_sel_n`=1 and `out_en_ref_n`=1 (standby), `dout_en` is 0 and `refresh_row` holds its value.
- R7: Each clock edge that sees `out_en_ref_n` fall while `chip_sel_n` is high advances `refresh_row` by exactly one.
- R8: With the request held low for L edges (counting the falling edge as edge 1) and L > SELF_ENTER, self refresh adds floor((L-SELF_ENTER-1)/SELF_PERIOD) further steps. With L <= SELF_ENTER, only the single auto step occurs.
- R9: Once `out_en_ref_n` returns high, or the chip is selected, self refresh stops and `refresh_row` no longer changes.
- R10: `refresh_row` wraps from 2047 to 0. `row_wrap` is high for exactly the one cycle in which the counter reads 0 after the wrap.
- R11: Only the low MEM_AW address bits select a cell. Addresses that differ only above bit MEM_AW-1 reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_n | input | 1 | Chip select, active low |
| out_en_ref_n | input | 1 | Output enable when selected, refresh request when deselected, active low |
| write_n | input | 1 | Write strobe, active low; data commits on its rise |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data |
| dout_en | output | 1 | High when `dout` is driven (low means high impedance) |
| refresh_row | output | ROW_BITS | Current refresh row counter |
| row_wrap | output | 1 | One-cycle pulse when the row counter wraps to 0 |

## Verification
A table of six address/data pairs is written and then read back. The addresses cover both ends of the array and alternating-bit patterns, which tells correct cell selection apart from stuck or swapped address lines. Directed cycles then move the address pins after the chip-select edge, and alias the high address bits, to separate the captured address from the live pins. The refresh pin is held low for lengths of 1, SELF_ENTER, SELF_ENTER+1, SELF_ENTER+1+SELF_PERIOD and a longer multiple. These lengths separate a plain auto step from a late or early entry into self refresh and from a timer that runs at the wrong rate. A full 2048-step run checks the wrap and its single pulse.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

    typedef enum logic [2:0] {
        PM_IDLE,
        PM_REFRESH,
        PM_READ,
        PM_WRITE,
        PM_QUIET
    } pmode_e;

    typedef struct packed {
        logic sel_n;
        logic oer_n;
        logic wr_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{sel_n: 1'b1, oer_n: 1'b1, wr_n: 1'b1};

    // Cycle type from the three control pins; chip select has priority,
    // then the write strobe, then the output enable.
    function automatic pmode_e decode_mode(pins_t p);
        if (p.sel_n) begin
            return p.oer_n ? PM_IDLE : PM_REFRESH;
        end
        if (!p.wr_n) begin
            return PM_WRITE;
        end
        if (!p.oer_n) begin
            return PM_READ;
        end
        return PM_QUIET;
    endfunction

    function automatic int unsigned width_for(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/psram_pin_dec.sv
`timescale 1ns/1ps
module psram_pin_dec
    import psram_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  pins_t             pins,
    input  logic [ADDR_W-1:0] addr,
    output pmode_e            mode,
    output logic              wr_commit,
    output logic              ref_fall,
    output logic [ADDR_W-1:0] cyc_addr
);

    pins_t             pins_q;
    logic [ADDR_W-1:0] addr_lat;
    logic              sel_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q   <= PINS_IDLE;
            addr_lat <= '0;
        end else begin
            pins_q <= pins;
            if (sel_fall) begin
                addr_lat <= addr;
            end
        end
    end

    always_comb begin
        mode      = decode_mode(pins);
        sel_fall  = pins_q.sel_n & ~pins.sel_n;
        wr_commit = ~pins_q.wr_n & pins.wr_n & ~pins_q.sel_n & ~pins.sel_n;
        ref_fall  = pins_q.oer_n & ~pins.oer_n & pins.sel_n;
        cyc_addr  = sel_fall ? addr : addr_lat;
    end

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!pins_q.sel_n && !pins.sel_n) |=> $stable(addr_lat));

    // R4
    commit_sel_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> (mode != PM_IDLE && mode != PM_REFRESH));

endmodule

// File: rtl/psram_refresh.sv
`timescale 1ns/1ps
module psram_refresh
    import psram_pkg::*;
#(
    parameter int ROW_BITS    = 11,
    parameter int SELF_ENTER  = 64,
    parameter int SELF_PERIOD = 780
) (
    input  logic                clk,
    input  logic                rst,
    input  pmode_e              mode,
    input  logic                ref_fall,
    output logic [ROW_BITS-1:0] row,
    output logic                wrap
);

    localparam int LOW_W = width_for(SELF_ENTER);
    localparam int TMR_W = width_for(SELF_PERIOD);
    localparam logic [ROW_BITS-1:0] ROW_TOP = '1;
    localparam logic [LOW_W-1:0]    LOW_LIM = LOW_W'(SELF_ENTER);
    localparam logic [TMR_W-1:0]    TMR_LIM = TMR_W'(SELF_PERIOD - 1);

    logic [LOW_W-1:0] low_cnt;
    logic [TMR_W-1:0] tmr;
    logic             self_act;
    logic             hold;
    logic             step;

    always_comb begin
        hold = (mode == PM_REFRESH);
        step = ref_fall | (self_act & hold & (tmr == TMR_LIM));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt  <= '0;
            tmr      <= '0;
            self_act <= 1'b0;
        end else if (!hold) begin
            low_cnt  <= '0;
            tmr      <= '0;
            self_act <= 1'b0;
        end else if (ref_fall) begin
            low_cnt  <= LOW_W'(1);
            tmr      <= '0;
            self_act <= 1'b0;
        end else if (self_act) begin
            tmr <= (tmr == TMR_LIM) ? '0 : tmr + 1'b1;
        end else if (low_cnt != '0) begin
            if (low_cnt == LOW_LIM) begin
                self_act <= 1'b1;
                tmr      <= '0;
            end else begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row  <= '0;
            wrap <= 1'b0;
        end else begin
            wrap <= step && (row == ROW_TOP);
            if (step) begin
                row <= row + 1'b1;
            end
        end
    end

    // R7
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row)) |-> (row == $past(row) + 1'b1));

    // R9
    row_only_deselected_chk: assert property (@(posedge clk) disable iff (rst)
        (row != $past(row)) |-> ($past(mode) == PM_REFRESH));

    // R10
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |-> (row == '0));

    // R10
    wrap_single_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> !wrap);

endmodule

// File: rtl/psram_array.sv
`timescale 1ns/1ps
module psram_array #(
    parameter int ADDR_W = 19,
    parameter int MEM_AW = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] cells [DEPTH];
    logic [MEM_AW-1:0] idx;

    generate
        if (MEM_AW < ADDR_W) begin : g_trunc
            assign idx = addr[MEM_AW-1:0];
        end else begin : g_full
            assign idx = MEM_AW'(addr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[idx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= cells[idx];
            end
        end
    end

endmodule

// File: rtl/psram_core.sv
`timescale 1ns/1ps
module psram_core
    import psram_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int MEM_AW      = 10,
    parameter int ROW_BITS    = 11,
    parameter int SELF_ENTER  = 64,
    parameter int SELF_PERIOD = 780
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                chip_sel_n,
    input  logic                out_en_ref_n,
    input  logic                write_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          din,
    output logic [7:0]          dout,
    output logic                dout_en,
    output logic [ROW_BITS-1:0] refresh_row,
    output logic                row_wrap
);

    pins_t             pins;
    pmode_e            mode;
    logic              wr_commit;
    logic              ref_fall;
    logic [ADDR_W-1:0] cyc_addr;

    assign pins = '{sel_n: chip_sel_n, oer_n: out_en_ref_n, wr_n: write_n};

    psram_pin_dec #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .pins      (pins),
        .addr      (addr),
        .mode      (mode),
        .wr_commit (wr_commit),
        .ref_fall  (ref_fall),
        .cyc_addr  (cyc_addr)
    );

    psram_refresh #(
        .ROW_BITS    (ROW_BITS),
        .SELF_ENTER  (SELF_ENTER),
        .SELF_PERIOD (SELF_PERIOD)
    ) u_ref (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .ref_fall (ref_fall),
        .row      (refresh_row),
        .wrap     (row_wrap)
    );

    psram_array #(
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW),
        .DATA_W (8)
    ) u_mem (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (mode == PM_READ),
        .wr_en  (wr_commit),
        .addr   (cyc_addr),
        .wdata  (din),
        .rdata  (dout),
        .rvalid (dout_en)
    );

    // R3
    drive_only_read_chk: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(!chip_sel_n && !out_en_ref_n && write_n));

    // R6
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(chip_sel_n && out_en_ref_n) |-> (!dout_en && $stable(refresh_row)));

endmodule

// File: tb/psram_core_test.sv
`timescale 1ns/1ps
module psram_core_test;

    localparam int AW    = 19;
    localparam int MAW   = 10;
    localparam int ENTER = 16;
    localparam int PER   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_sel_n = 1'b1;
    logic          out_en_ref_n = 1'b1;
    logic          write_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_en;
    logic [10:0]   refresh_row;
    logic          row_wrap;

    int checks = 0;
    int fails  = 0;
    int wrap_seen = 0;

    always #10 clk = ~clk;

    psram_core #(
        .ADDR_W(AW), .MEM_AW(MAW), .ROW_BITS(11),
        .SELF_ENTER(ENTER), .SELF_PERIOD(PER)
    ) uut (
        .clk(clk), .rst(rst), .chip_sel_n(chip_sel_n), .out_en_ref_n(out_en_ref_n),
        .write_n(write_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .refresh_row(refresh_row), .row_wrap(row_wrap)
    );

    always @(negedge clk) if (row_wrap) wrap_seen++;

    // {address, data}
    localparam logic [26:0] VEC [6] = '{
        {19'h00000, 8'hA5}, {19'h003FF, 8'h5A}, {19'h00155, 8'h3C},
        {19'h002AA, 8'hC3}, {19'h00007, 8'h01}, {19'h00200, 8'hFE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        chip_sel_n = 1'b0; out_en_ref_n = 1'b1; write_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        write_n = 1'b1;
        @(negedge clk);
        chip_sel_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [7:0] d, output logic en);
        @(negedge clk);
        chip_sel_n = 1'b0; out_en_ref_n = 1'b0; write_n = 1'b1; addr = a;
        @(negedge clk);
        d = dout; en = dout_en;
        chip_sel_n = 1'b1; out_en_ref_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ref_low(input int n);
        @(negedge clk);
        out_en_ref_n = 1'b0;
        repeat (n) @(negedge clk);
        out_en_ref_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       en;

        repeat (3) @(negedge clk);
        chk("R1 dout_en", dout_en, 0);
        chk("R1 row", refresh_row, 0);
        chk("R1 wrap", row_wrap, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {dout_en, row_wrap, 21'(refresh_row)}, 0);

        // table: write all, then read each back (R3, R4)
        for (int i = 0; i < 12; i++) begin
            if (i < 6) begin
                do_write(VEC[i][26:8], VEC[i][7:0]);
            end else begin
                do_read(VEC[i-6][26:8], rd, en);
                chk("R3 read data", rd, VEC[i-6][7:0]);
                chk("R3 dout_en", en, 1);
            end
        end

        // R2: address moves after chip select falls
        @(negedge clk);
        chip_sel_n = 1'b0; out_en_ref_n = 1'b0; addr = 19'h00155;
        @(negedge clk);
        chk("R2 first", dout, 8'h3C);
        addr = 19'h002AA;
        @(negedge clk);
        chk("R2 ignored addr", dout, 8'h3C);
        chip_sel_n = 1'b1; out_en_ref_n = 1'b1;
        @(negedge clk);

        // R4: write goes to captured address
        do_write(19'h00041, 8'h11);
        @(negedge clk);
        chip_sel_n = 1'b0; write_n = 1'b0; addr = 19'h00040; din = 8'h99;
        @(negedge clk);
        addr = 19'h00041;
        write_n = 1'b1;
        @(negedge clk);
        chip_sel_n = 1'b1;
        @(negedge clk);
        do_read(19'h00040, rd, en);
        chk("R4 captured addr", rd, 8'h99);
        do_read(19'h00041, rd, en);
        chk("R4 other untouched", rd, 8'h11);

        // R5: selected, outputs off
        @(negedge clk);
        chip_sel_n = 1'b0; out_en_ref_n = 1'b1; write_n = 1'b1; addr = 19'h00040; din = 8'h00;
        repeat (3) @(negedge clk);
        chk("R5 dout_en", dout_en, 0);
        chip_sel_n = 1'b1;
        @(negedge clk);
        do_read(19'h00040, rd, en);
        chk("R5 no write", rd, 8'h99);

        // R11: aliasing above MEM_AW
        do_write(19'h00012, 8'h3C);
        do_read(19'h40412, rd, en);
        chk("R11 alias", rd, 8'h3C);

        // refresh
        chk("R6 row before refresh", refresh_row, 0);
        ref_low(1);
        chk("R7 auto step", refresh_row, 1);
        ref_low(ENTER);
        chk("R8 at limit", refresh_row, 2);
        ref_low(ENTER + 1);
        chk("R8 entry no step yet", refresh_row, 3);
        ref_low(ENTER + 1 + 3 * PER);
        chk("R8 self steps", refresh_row, 7);
        repeat (30) @(negedge clk);
        chk("R9 stopped", refresh_row, 7);
        ref_low(ENTER + 1 + PER);
        chk("R8 one period", refresh_row, 9);
        repeat (20) @(negedge clk);
        chk("R6 standby row", refresh_row, 9);
        chk("R6 standby dout_en", dout_en, 0);
        chk("R10 no early wrap", wrap_seen, 0);

        // R10: full wrap
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        wrap_seen = 0;
        chk("R1 after second reset", refresh_row, 0);
        ref_low(ENTER + 1 + PER * 2047);
        chk("R10 row wrapped", refresh_row, 0);
        chk("R10 one wrap pulse", wrap_seen, 1);
        ref_low(1);
        chk("R10 after wrap", refresh_row, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule